// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Hysteretic Source Throttling

This block buffers an 8-bit byte stream from a fast, bursty writer into a slower reader that drains one byte per read clock whenever data is present. The two sides run on unrelated clocks. The read and write pointers cross between the clocks in Gray code through a configurable chain of synchroniser flops.

Instead of a plain full flag, the write side compares its view of the occupancy against two programmable levels. It raises a stop request once the fill reaches the high level. It keeps that request asserted until the fill drains down to the low level. The source then pauses at whole-frame granularity and resumes with a fresh frame. The gap between the high level and the depth has to absorb the source's reaction time plus the synchroniser lag. A byte offered while the buffer is truly full is discarded and latched as an error.

Top module: `hyst_byte_fifo`

## Requirements
- R1: While either reset is held and right after its release, `rd_empty` is 1 and `stop_req`, `overflow_err` and `rd_valid` are 0.
- R2: Bytes come out in exactly the order they were accepted, with no duplication or loss, across the two clock domains.
- R3: A byte offered while the write-side occupancy equals DEPTH is not stored, the write pointer does not move, and `overflow_err` becomes 1.
- R4: One write clock after the write-side occupancy is at or above `thr_hi`, `stop_req` is 1.
- R5: While the write-side occupancy lies strictly between `thr_lo` and `thr_hi`, `stop_req` keeps its previous value.
- R6: One write clock after the write-side occupancy is at or below `thr_lo` (and below `thr_hi`), `stop_req` is 0.
- R7: A read request while `rd_empty` is 1 yields `rd_valid` = 0 on the next read clock and does not consume any byte.
- R8: A read request while `rd_empty` is 0 yields `rd_valid` = 1 on the next read clock, with `rd_data` holding the oldest stored byte.
- R9: `overflow_err` stays 1 once set, until write reset.
- R10: The buffer holds exactly DEPTH bytes, and the write-side occupancy never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_valid | input | 1 | Byte offered on `wr_data` this cycle |
| wr_data | input | 8 | Byte to store |
| thr_hi | input | $clog2(DEPTH)+1 | Occupancy at which the stop request is raised |
| thr_lo | input | $clog2(DEPTH)+1 | Occupancy at which the stop request is released |
| stop_req | output | 1 | Level asking the source to pause after its current frame |
| overflow_err | output | 1 | Sticky flag: a byte was dropped because the buffer was full |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_en | input | 1 | Request to take one byte |
| rd_data | output | 8 | Byte delivered by the previous accepted request |
| rd_valid | output | 1 | `rd_data` carries a fresh byte this cycle |
| rd_empty | output | 1 | No byte visible to the read side |

## Verification
The hysteresis properties assume that `thr_lo` is below `thr_hi`, and that both levels stay constant between resets. The bench programs each pair of levels before traffic starts. It keeps the low level strictly under the high one. Threshold checks are made only after both pointer chains have settled. At that point the write-side occupancy equals the true fill, so the expected stop level can be worked out from the byte count alone. The streaming scenario lets the writer obey `stop_req` on every write clock, so no byte is ever offered against a full buffer there.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
   typedef logic [7:0] byte_t;

   typedef enum logic {
      FLOW_GO   = 1'b0,
      FLOW_HOLD = 1'b1
   } flow_e;
endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hbf_mem.sv
module hbf_mem #(
   parameter int AW = 4
) (
   input  logic                wr_clk,
   input  logic                wr_en,
   input  logic [AW-1:0]       wr_addr,
   input  hbf_pkg::byte_t      wr_data,
   input  logic                rd_clk,
   input  logic                rd_en,
   input  logic [AW-1:0]       rd_addr,
   output hbf_pkg::byte_t      rd_data
);
   localparam int DEPTH = 1 << AW;

   hbf_pkg::byte_t store [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   always_ff @(posedge rd_clk) begin
      if (rd_en) rd_data <= store[rd_addr];
   end
endmodule

// File: rtl/hbf_wr_ctrl.sv
module hbf_wr_ctrl #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic [AW:0]   rd_gray_sync,
   input  logic [AW:0]   thr_hi,
   input  logic [AW:0]   thr_lo,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [AW:0]   wr_gray,
   output logic [AW:0]   level,
   output logic          full,
   output logic          stop_req,
   output logic          overflow_err
);
   import hbf_pkg::*;

   localparam int PW = AW + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

   logic [PW-1:0] wptr_q;
   logic [PW-1:0] wptr_nxt;
   logic [PW-1:0] rsync_bin;
   logic          accept;
   logic          ovf_q;
   flow_e         flow_q;

   always_comb begin
      for (int i = 0; i < PW; i++) begin
         rsync_bin[i] = ^(rd_gray_sync >> i);
      end
   end

   assign level    = wptr_q - rsync_bin;
   assign full     = (level == DEPTH_P);
   assign accept   = wr_valid && !full;
   assign wptr_nxt = wptr_q + PW'(accept);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         wr_gray <= '0;
      end else begin
         wptr_q  <= wptr_nxt;
         wr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ovf_q <= 1'b0;
      else if (wr_valid && full)  ovf_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flow_q <= FLOW_GO;
      else if (level >= thr_hi)  flow_q <= FLOW_HOLD;
      else if (level <= thr_lo)  flow_q <= FLOW_GO;
   end

   assign mem_we       = accept;
   assign mem_addr     = wptr_q[AW-1:0];
   assign stop_req     = (flow_q == FLOW_HOLD);
   assign overflow_err = ovf_q;
endmodule

// File: rtl/hbf_rd_ctrl.sv
module hbf_rd_ctrl #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW:0]   wr_gray_sync,
   output logic          mem_re,
   output logic [AW-1:0] mem_addr,
   output logic [AW:0]   rd_gray,
   output logic          empty,
   output logic          valid
);
   localparam int PW = AW + 1;

   logic [PW-1:0] rptr_q;
   logic [PW-1:0] rptr_nxt;
   logic          fire;

   assign empty    = (rd_gray == wr_gray_sync);
   assign fire     = rd_en && !empty;
   assign rptr_nxt = rptr_q + PW'(fire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q  <= '0;
         rd_gray <= '0;
         valid   <= 1'b0;
      end else begin
         rptr_q  <= rptr_nxt;
         rd_gray <= rptr_nxt ^ (rptr_nxt >> 1);
         valid   <= fire;
      end
   end

   assign mem_re   = fire;
   assign mem_addr = rptr_q[AW-1:0];
endmodule

// File: rtl/hyst_byte_fifo.sv
module hyst_byte_fifo #(
   parameter int DEPTH       = 512,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = $clog2(DEPTH)
) (
   input  logic        wr_clk,
   input  logic        wr_rst_n,
   input  logic        wr_valid,
   input  logic [7:0]  wr_data,
   input  logic [AW:0] thr_hi,
   input  logic [AW:0] thr_lo,
   output logic        stop_req,
   output logic        overflow_err,
   input  logic        rd_clk,
   input  logic        rd_rst_n,
   input  logic        rd_en,
   output logic [7:0]  rd_data,
   output logic        rd_valid,
   output logic        rd_empty
);
   localparam int PW = AW + 1;

   generate
      if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
         initial $fatal(1, "hyst_byte_fifo: DEPTH must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         initial $fatal(1, "hyst_byte_fifo: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PW-1:0] wr_ptr_gray;
   logic [PW-1:0] rd_ptr_gray;
   logic [PW-1:0] wr_gray_at_rd;
   logic [PW-1:0] rd_gray_at_wr;
   logic [PW-1:0] wr_level;
   logic          wr_full;
   logic          mem_we;
   logic          mem_re;
   logic [AW-1:0] mem_waddr;
   logic [AW-1:0] mem_raddr;

   hbf_wr_ctrl #(.AW(AW)) u_wr (
      .clk          (wr_clk),
      .rst_n        (wr_rst_n),
      .wr_valid     (wr_valid),
      .rd_gray_sync (rd_gray_at_wr),
      .thr_hi       (thr_hi),
      .thr_lo       (thr_lo),
      .mem_we       (mem_we),
      .mem_addr     (mem_waddr),
      .wr_gray      (wr_ptr_gray),
      .level        (wr_level),
      .full         (wr_full),
      .stop_req     (stop_req),
      .overflow_err (overflow_err)
   );

   hbf_rd_ctrl #(.AW(AW)) u_rd (
      .clk          (rd_clk),
      .rst_n        (rd_rst_n),
      .rd_en        (rd_en),
      .wr_gray_sync (wr_gray_at_rd),
      .mem_re       (mem_re),
      .mem_addr     (mem_raddr),
      .rd_gray      (rd_ptr_gray),
      .empty        (rd_empty),
      .valid        (rd_valid)
   );

   hbf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk   (rd_clk),
      .rst_n (rd_rst_n),
      .d     (wr_ptr_gray),
      .q     (wr_gray_at_rd)
   );

   hbf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk   (wr_clk),
      .rst_n (wr_rst_n),
      .d     (rd_ptr_gray),
      .q     (rd_gray_at_wr)
   );

   hbf_mem #(.AW(AW)) u_mem (
      .wr_clk  (wr_clk),
      .wr_en   (mem_we),
      .wr_addr (mem_waddr),
      .wr_data (wr_data),
      .rd_clk  (rd_clk),
      .rd_en   (mem_re),
      .rd_addr (mem_raddr),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/hbf_checker.sv
module hbf_checker #(
   parameter int PW    = 5,
   parameter int DEPTH = 16
) (
   input logic          wr_clk,
   input logic          wr_rst_n,
   input logic          rd_clk,
   input logic          rd_rst_n,
   input logic          rd_en,
   input logic          rd_empty,
   input logic          rd_valid,
   input logic          stop_req,
   input logic          overflow_err,
   input logic [PW-1:0] thr_hi,
   input logic [PW-1:0] thr_lo,
   input logic [PW-1:0] wr_level,
   input logic          wr_full,
   input logic [PW-1:0] wr_ptr_gray
);
   assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_full |=> $stable(wr_ptr_gray));

   assert_stop_rise_R4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_level >= thr_hi) |=> stop_req);

   assert_stop_hold_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_level > thr_lo && wr_level < thr_hi) |=> (stop_req == $past(stop_req)));

   assert_stop_fall_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_level <= thr_lo && wr_level < thr_hi) |=> !stop_req);

   assert_empty_read_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_empty || !rd_en) |=> !rd_valid);

   assert_read_valid_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_en && !rd_empty) |=> rd_valid);

   assert_sticky_error_R9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      overflow_err |=> overflow_err);

   assert_level_bound_R10: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      wr_level <= PW'(DEPTH));
endmodule

bind hyst_byte_fifo hbf_checker #(.PW(PW), .DEPTH(DEPTH)) u_chk (
   .wr_clk       (wr_clk),
   .wr_rst_n     (wr_rst_n),
   .rd_clk       (rd_clk),
   .rd_rst_n     (rd_rst_n),
   .rd_en        (rd_en),
   .rd_empty     (rd_empty),
   .rd_valid     (rd_valid),
   .stop_req     (stop_req),
   .overflow_err (overflow_err),
   .thr_hi       (thr_hi),
   .thr_lo       (thr_lo),
   .wr_level     (wr_level),
   .wr_full      (wr_full),
   .wr_ptr_gray  (wr_ptr_gray)
);

// File: tb/hyst_byte_fifo_bench.sv
module hyst_byte_fifo_bench;
   localparam int CLK_PERIOD    = 8;
   localparam int RD_CLK_PERIOD = 10;
   localparam int DEPTH         = 16;
   localparam int AW            = $clog2(DEPTH);

   logic          wr_clk = 1'b0;
   logic          rd_clk = 1'b0;
   logic          wr_rst_n = 1'b0;
   logic          rd_rst_n = 1'b0;
   logic          wr_valid = 1'b0;
   logic [7:0]    wr_data = '0;
   logic [AW:0]   thr_hi = 5'd12;
   logic [AW:0]   thr_lo = 5'd4;
   logic          stop_req;
   logic          overflow_err;
   logic          rd_en = 1'b0;
   logic [7:0]    rd_data;
   logic          rd_valid;
   logic          rd_empty;

   int            checks = 0;
   int            failures = 0;
   logic [7:0]    exp_q[$];
   logic [7:0]    seed = 8'h3c;

   always #(CLK_PERIOD/2)    wr_clk = ~wr_clk;
   always #(RD_CLK_PERIOD/2) rd_clk = ~rd_clk;

   hyst_byte_fifo #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u_hyst_byte_fifo (
      .wr_clk       (wr_clk),
      .wr_rst_n     (wr_rst_n),
      .wr_valid     (wr_valid),
      .wr_data      (wr_data),
      .thr_hi       (thr_hi),
      .thr_lo       (thr_lo),
      .stop_req     (stop_req),
      .overflow_err (overflow_err),
      .rd_clk       (rd_clk),
      .rd_rst_n     (rd_rst_n),
      .rd_en        (rd_en),
      .rd_data      (rd_data),
      .rd_valid     (rd_valid),
      .rd_empty     (rd_empty)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] next_byte();
      seed = {seed[6:0], seed[7] ^ seed[5] ^ seed[4] ^ seed[3]};
      return seed;
   endfunction

   task automatic settle();
      repeat (5) @(posedge rd_clk);
      repeat (5) @(posedge wr_clk);
      @(negedge wr_clk);
   endtask

   task automatic do_reset();
      wr_valid = 1'b0;
      rd_en    = 1'b0;
      wr_rst_n = 1'b0;
      rd_rst_n = 1'b0;
      exp_q.delete();
      repeat (3) @(posedge wr_clk);
      @(negedge wr_clk);
      wr_rst_n = 1'b1;
      rd_rst_n = 1'b1;
      settle();
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge wr_clk);
      wr_valid = 1'b1;
      wr_data  = b;
      @(negedge wr_clk);
      wr_valid = 1'b0;
      if (exp_q.size() < DEPTH) exp_q.push_back(b);
   endtask

   task automatic pop_expect(input string req);
      logic [7:0] e;
      @(negedge rd_clk);
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
      e = exp_q.pop_front();
      check(rd_valid === 1'b1, req, int'(rd_valid), 1);
      check(rd_data === e, req, int'(rd_data), int'(e));
   endtask

   task automatic test_reset_state();
      do_reset();
      check(rd_empty === 1'b1, "R1 empty", int'(rd_empty), 1);
      check(stop_req === 1'b0, "R1 stop", int'(stop_req), 0);
      check(overflow_err === 1'b0, "R1 overflow", int'(overflow_err), 0);
      check(rd_valid === 1'b0, "R1 valid", int'(rd_valid), 0);
   endtask

   task automatic test_empty_read();
      @(negedge rd_clk);
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
      check(rd_valid === 1'b0, "R7 empty read valid", int'(rd_valid), 0);
      push(8'ha5);
      settle();
      pop_expect("R7 byte kept after empty read");
   endtask

   task automatic test_hysteresis();
      do_reset();
      thr_hi = 5'd12;
      thr_lo = 5'd4;
      for (int n = 1; n <= 12; n++) begin
         push(next_byte());
         settle();
         if (n < 12) check(stop_req === 1'b0, "R5 below high on rise", int'(stop_req), 0);
         else        check(stop_req === 1'b1, "R4 high level reached", int'(stop_req), 1);
      end
      for (int n = 11; n >= 4; n--) begin
         pop_expect("R8 drain order");
         settle();
         if (n > 4) check(stop_req === 1'b1, "R5 held while draining", int'(stop_req), 1);
         else       check(stop_req === 1'b0, "R6 low level reached", int'(stop_req), 0);
      end
      for (int n = 5; n <= 11; n++) begin
         push(next_byte());
         settle();
         check(stop_req === 1'b0, "R5 released while refilling", int'(stop_req), 0);
      end
      while (exp_q.size() > 0) pop_expect("R2 order after refill");
      settle();
      check(rd_empty === 1'b1, "R2 empty after drain", int'(rd_empty), 1);
   endtask

   task automatic test_stream();
      int got = 0;
      int stops = 0;
      do_reset();
      thr_hi = 5'd10;
      thr_lo = 5'd3;
      fork
         begin
            int i = 0;
            while (i < 60) begin
               @(negedge wr_clk);
               if (stop_req) begin
                  wr_valid = 1'b0;
                  stops++;
               end else begin
                  wr_valid = 1'b1;
                  wr_data  = next_byte();
                  exp_q.push_back(wr_data);
                  i++;
               end
            end
            @(negedge wr_clk);
            wr_valid = 1'b0;
         end
         begin
            @(negedge rd_clk);
            rd_en = 1'b1;
            while (got < 60) begin
               @(negedge rd_clk);
               if (rd_valid) begin
                  logic [7:0] e;
                  e = exp_q.pop_front();
                  check(rd_data === e, "R2 streamed byte", int'(rd_data), int'(e));
                  got++;
               end
            end
            rd_en = 1'b0;
         end
      join
      check(stops > 0, "R4 stop seen under load", stops, 1);
      check(overflow_err === 1'b0, "R3 no drop under flow control", int'(overflow_err), 0);
   endtask

   task automatic test_full_overflow();
      do_reset();
      thr_hi = 5'd15;
      thr_lo = 5'd2;
      for (int n = 0; n < DEPTH; n++) push(next_byte());
      settle();
      check(overflow_err === 1'b0, "R10 full without drop", int'(overflow_err), 0);
      push(8'hee);
      settle();
      check(overflow_err === 1'b1, "R3 drop sets error", int'(overflow_err), 1);
      for (int n = 0; n < DEPTH; n++) pop_expect("R10 all depth bytes returned");
      settle();
      check(rd_empty === 1'b1, "R3 dropped byte not stored", int'(rd_empty), 1);
      @(negedge rd_clk);
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
      check(rd_valid === 1'b0, "R7 read past end", int'(rd_valid), 0);
      check(overflow_err === 1'b1, "R9 error stays set", int'(overflow_err), 1);
      do_reset();
      check(overflow_err === 1'b0, "R9 error cleared by reset", int'(overflow_err), 0);
   endtask

   initial begin
      repeat (150000) @(posedge wr_clk);
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      test_reset_state();
      test_empty_read();
      test_hysteresis();
      test_stream();
      test_full_overflow();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule